// File: doc/BRIEF.md
# Interrupt Routing Autodetect Detector

This block listens to configuration-space write traffic seen on a snoop port and works out which interrupt routing the host software expects. When software writes the interrupt-line byte of a device's configuration header, the written value is compared with a set of signatures that depend on the slot. Some values show that the software assumes an older, incorrect routing. Other values show that the software is aware of the correct routing. Values that fit both readings are ambiguous and leave the decision open.

The block starts from a preset state loaded at reset. While the state is still undecided, the first write that gives a clear answer moves the state to "legacy routing" or "correct routing". Once decided, the state stays fixed until the next reset. On the second board variant, detection is switched off entirely. The 2-bit output drives a downstream interrupt router.

Top module: `irq_route_detect`

## Requirements
- R1: At reset the state output takes the value of `preset_state` (encoding 0 = undecided, 1 = legacy routing, 2 = correct routing).
- R2: A snooped write is examined only when `wr_addr[7:0]` equals 0x3C. Writes to any other offset leave the state unchanged.
- R3: The slot is `wr_addr[15:11]` (device/function bits [7:3]), reduced modulo 4. Slots that differ by a multiple of 4 classify the same way.
- R4: Written value 27 leaves the state undecided when slot mod 4 is 2, and selects legacy routing (1) for every other slot mod 4.
- R5: Written value (slot mod 4) + 27, or (slot mod 4) + 91, selects legacy routing (1).
- R6: Any other written value selects correct routing (2).
- R7: Once the state is 1 or 2, no write changes it until reset.
- R8: When `variant_b` is 1, no write changes the state.
- R9: The state changes on the first clock edge after a qualifying write, and only when `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_b | input | 1 | 1 disables detection (second board variant) |
| preset_state | input | 2 | State loaded at reset |
| wr_en | input | 1 | Snooped configuration write strobe |
| wr_addr | input | 24 | Configuration address of the write |
| wr_data | input | 8 | Byte written |
| map_state | output | 2 | Current routing decision |

## Verification
The bench builds the block with its default parameters: a 24-bit address, an 8-bit data byte, interrupt-line offset 0x3C, base value 27 and offset 64. With these values, every slot residue can be reached through slots 0 to 31. The bench drives each signature value for each residue, including the ambiguous case of value 27 in slot 2. It also checks the lock after a decision, the disable on the second variant, and all three reset presets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    MAP_UNDECIDED = 2'd0,
    MAP_LEGACY    = 2'd1,
    MAP_CORRECT   = 2'd2
  } map_state_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int LINE_OFS = 60,
  parameter int SLOT_MOD = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit,
  output logic [1:0]        slot_res
);
  localparam int SLOT_LSB = 11;
  localparam int RES_W    = $clog2(SLOT_MOD);
  logic [4:0] slot;
  assign slot     = wr_addr[SLOT_LSB +: 5];
  assign slot_res = 2'(slot[RES_W-1:0]);
  assign hit      = wr_en && (wr_addr[7:0] == 8'(LINE_OFS));
endmodule

// File: rtl/irq_route_classify.sv
module irq_route_classify
  import irq_route_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BASE_IRQ = 27,
  parameter int HI_OFS   = 64,
  parameter int AMBIG_RES = 2
) (
  input  logic [1:0]        slot_res,
  input  logic [DATA_W-1:0] value,
  output map_state_t        verdict
);
  function automatic map_state_t classify(input logic [1:0] r, input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] lo_sig, hi_sig;
    lo_sig = DATA_W'(BASE_IRQ) + DATA_W'(r);
    hi_sig = lo_sig + DATA_W'(HI_OFS);
    if (v == DATA_W'(BASE_IRQ))
      return (r == 2'(AMBIG_RES)) ? MAP_UNDECIDED : MAP_LEGACY;
    if (v == lo_sig || v == hi_sig) return MAP_LEGACY;
    return MAP_CORRECT;
  endfunction

  assign verdict = classify(slot_res, value);
endmodule

// File: rtl/irq_route_detect.sv
module irq_route_detect
  import irq_route_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int LINE_OFS = 60,
  parameter int BASE_IRQ = 27,
  parameter int HI_OFS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              variant_b,
  input  logic [1:0]        preset_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        map_state
);
  logic       hit;
  logic [1:0] slot_res;
  map_state_t verdict;
  map_state_t state_q;
  logic       open_q;
  logic       take;

  irq_route_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFS(LINE_OFS)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit), .slot_res(slot_res));

  irq_route_classify #(.DATA_W(DATA_W), .BASE_IRQ(BASE_IRQ), .HI_OFS(HI_OFS)) u_cls (
    .slot_res(slot_res), .value(wr_data), .verdict(verdict));

  assign open_q = (state_q == MAP_UNDECIDED);
  assign take   = hit && open_q && !variant_b;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= map_state_t'(preset_state);
    else if (take) state_q <= verdict;
  end

  assign map_state = state_q;
endmodule

// File: rtl/irq_route_detect_chk.sv
module irq_route_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       variant_b,
  input logic       hit,
  input logic       wr_en,
  input logic [1:0] map_state
);
  // R7
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_state != 2'd0) |=> $stable(map_state));
  // R8
  p_variant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    variant_b |=> $stable(map_state));
  // R2
  p_nohit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(map_state));
  // R9
  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(map_state));
  // R1 legal encoding
  p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    map_state != 2'd3);
endmodule

bind irq_route_detect irq_route_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .variant_b(variant_b), .hit(hit),
  .wr_en(wr_en), .map_state(map_state));

// File: tb/irq_route_detect_bench.sv
module irq_route_detect_bench;
  logic clk = 0, rst_n = 0, variant_b = 0, wr_en = 0;
  logic [1:0] preset_state = 0;
  logic [23:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] map_state;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_route_detect u_irq_route_detect (.*);

  function automatic logic [1:0] model(int slot, int v);
    int r = slot % 4;
    if (v == 27) return (r == 2) ? 2'd0 : 2'd1;
    if (v == r + 27 || v == r + 91) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(string req, logic [1:0] exp);
    n_chk++;
    if (map_state !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, map_state, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] p, logic vb);
    preset_state = p; variant_b = vb; rst_n = 0;
    @(posedge clk); @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic write(int slot, int ofs, int v, logic en = 1);
    wr_addr = {8'd0, 5'(slot), 3'd0, 8'(ofs)}; wr_data = 8'(v); wr_en = en;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic t_reset_presets();
    for (int p = 0; p < 3; p++) begin
      do_reset(2'(p), 0); check("R1 preset", 2'(p));
    end
  endtask

  task automatic t_signatures();
    for (int s = 0; s < 8; s++) begin
      int vals[4] = '{27, 27 + s % 4, 91 + s % 4, 200};
      foreach (vals[i]) begin
        do_reset(0, 0); write(s, 60, vals[i]);
        check($sformatf("R3 R4 R5 R6 slot %0d val %0d", s, vals[i]), model(s, vals[i]));
      end
    end
    do_reset(0, 0); write(30, 60, 29); check("R3 slot 30 val 29", 2'd1);
  endtask

  task automatic t_offset_strobe();
    do_reset(0, 0); write(0, 61, 5); check("R2 other offset", 0);
    write(0, 60, 5, 0); check("R9 no strobe", 0);
    wr_addr = {8'd0, 5'd0, 3'd0, 8'd60}; wr_data = 8'd5; wr_en = 1;
    #1 check("R9 not before edge", 0);
    @(posedge clk); #1 wr_en = 0; check("R9 after edge", 2);
  endtask

  task automatic t_lock();
    do_reset(0, 0); write(2, 60, 27); check("R4 ambiguous stays open", 0);
    write(1, 60, 28); check("R5 then legacy", 1);
    write(0, 60, 200); check("R7 locked legacy", 1);
    do_reset(0, 0); write(3, 60, 77); check("R6 correct", 2);
    write(0, 60, 27); check("R7 locked correct", 2);
  endtask

  task automatic t_variant();
    do_reset(0, 1); write(0, 60, 27); write(1, 60, 99); check("R8 variant b hold", 0);
    do_reset(1, 1); write(0, 60, 200); check("R8 variant b preset", 1);
  endtask

  initial begin
    t_reset_presets();
    t_signatures();
    t_offset_strobe();
    t_lock();
    t_variant();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog: got 1 expected 0"); end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule